// File: doc/BRIEF.md
# Touch Panel Driver Switch Sequencer

This block decides, clock by clock, which excitation switches of a four-wire resistive touch panel are closed. It takes the decoded fields of the converter's control word: the channel address, the single-ended/ratiometric mode bit and the two-bit power-down code. It also takes three phase strobes from the conversion sequencer (acquire, conversion start and conversion end) and the active-low chip select. From these it drives three enables: one for the X-plate drivers, one for the Y-plate drivers and one for the Y– pull switch.

Measuring the X+ channel excites the Y plate, and measuring the Y+ channel excites the X plate. Every other channel, including the supply-monitor and temperature inputs, leaves both plates idle. In single-ended mode the plate is excited only while the input is being acquired. In ratiometric mode the excitation also spans the conversion. The power-down code sets what happens after the conversion ends. With one code the plate stays driven until the configuration changes or the part is deselected. Every other code releases the plate and closes the Y– switch, so that a pen touch can be detected. All outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

Top module: `tps_switch_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all three enables are 0.
- R2: The channel address is captured on every acquire cycle and on the conversion-start cycle. Address 3'b001 selects the Y drivers (y_drv_en) and address 3'b101 selects the X drivers (x_drv_en). Any other address (for example 000, 010, 110, 111) leaves both driver enables at 0 in every phase.
- R3: With single_ended=1, the selected driver enable is 1 on the cycle after an acquire cycle. It is 0 from the cycle after conv_start onward.
- R4: With single_ended=0, the selected driver enable stays 1 through every cycle from the first acquire cycle until the cycle after conv_end.
- R5: When conv_end arrives during a conversion with a captured power-down code of 00, 01 or 10, both driver enables go to 0 and yneg_sw_en goes to 1 on the next cycle. yneg_sw_en stays 1 until the cycle after the next acquire or conv_start cycle.
- R6: When conv_end arrives with a captured power-down code of 11 and single_ended=0, the selected driver stays enabled afterwards and yneg_sw_en stays 0. In the same case with single_ended=1, the driver is released and yneg_sw_en stays 0.
- R7: A held driver (see R6) is released on the cycle after chan_sel, single_ended or pd_mode differs from the values captured for the frame.
- R8: cs_n=1 forces both driver enables to 0 on the next cycle and ends any phase. yneg_sw_en keeps its value.
- R9: x_drv_en and y_drv_en are never 1 together, and yneg_sw_en is never 1 together with either of them.
- R10: Strobe priority within one cycle, from highest to lowest: cs_n high, then acq_phase, then conv_start, then conv_end. conv_end has an effect only while a conversion is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| chan_sel | input | 3 | Channel address field of the control word |
| single_ended | input | 1 | 1 = single-ended, 0 = ratiometric |
| pd_mode | input | 2 | Power-down code field |
| acq_phase | input | 1 | High on each acquisition cycle |
| conv_start | input | 1 | One-cycle strobe: conversion begins |
| conv_end | input | 1 | One-cycle strobe: conversion finished |
| x_drv_en | output | 1 | Enable for the X-plate drivers |
| y_drv_en | output | 1 | Enable for the Y-plate drivers |
| yneg_sw_en | output | 1 | Enable for the Y– pull switch |

## Verification
A wrong phase state shows as a plate left excited or released one cycle after the faulty transition. This is visible at once, because every output is a register one edge behind its cause. A stale captured channel moves the excitation to the other plate or drops it, while a stale power-down code swaps the hold and Y– outcomes at conversion end. A stuck Y– flag is caught either by its overlap with a driver enable or by its failure to clear after the next acquisition.

// File: rtl/tps_pkg.sv
package tps_pkg;

  localparam int TPS_ADDR_W = 3;
  localparam int TPS_PD_W   = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  typedef struct packed {
    logic [TPS_ADDR_W-1:0] chan;
    logic                  se;
    logic [TPS_PD_W-1:0]   pd;
  } frame_cfg_t;

  // Plate excitation wanted in a given phase for a given mode.
  function automatic logic plate_wanted(input phase_e ph, input logic se);
    case (ph)
      PH_ACQ:  plate_wanted = 1'b1;
      PH_CONV: plate_wanted = ~se;
      PH_HOLD: plate_wanted = 1'b1;
      default: plate_wanted = 1'b0;
    endcase
  endfunction

  // Hold after conversion: only ratiometric with the hold code.
  function automatic logic hold_after_conv(input frame_cfg_t c,
                                           input logic [TPS_PD_W-1:0] hold_code);
    hold_after_conv = (c.pd == hold_code) && !c.se;
  endfunction

  // Y- pull closes after conversion for every non-hold code.
  function automatic logic pull_after_conv(input frame_cfg_t c,
                                           input logic [TPS_PD_W-1:0] hold_code);
    pull_after_conv = (c.pd != hold_code);
  endfunction

endpackage

// File: rtl/tps_cfg_latch.sv
module tps_cfg_latch
  import tps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  frame_cfg_t cfg_in,
  output frame_cfg_t cfg_q,
  output logic       cfg_diff
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (capture) cfg_q <= cfg_in;
  end

  assign cfg_diff = (cfg_in != cfg_q);

endmodule

// File: rtl/tps_phase_fsm.sv
module tps_phase_fsm
  import tps_pkg::*;
#(
  parameter logic [TPS_PD_W-1:0] PD_HOLD = 2'b11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_deselect,
  input  logic       ev_acq,
  input  logic       ev_conv_start,
  input  logic       ev_conv_end,
  input  logic       ev_release,
  input  frame_cfg_t cfg_q,
  output phase_e     phase_q,
  output logic       yneg_q
);

  phase_e phase_d;
  logic   yneg_d;

  always_comb begin
    phase_d = phase_q;
    yneg_d  = yneg_q;
    if (ev_deselect) begin
      phase_d = PH_IDLE;
    end else if (ev_acq) begin
      phase_d = PH_ACQ;
      yneg_d  = 1'b0;
    end else if (ev_conv_start) begin
      phase_d = PH_CONV;
      yneg_d  = 1'b0;
    end else if (ev_conv_end) begin
      phase_d = hold_after_conv(cfg_q, PD_HOLD) ? PH_HOLD : PH_IDLE;
      yneg_d  = pull_after_conv(cfg_q, PD_HOLD);
    end else if (ev_release) begin
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      yneg_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      yneg_q  <= yneg_d;
    end
  end

endmodule

// File: rtl/tps_drive_map.sv
module tps_drive_map
  import tps_pkg::*;
#(
  parameter logic [TPS_ADDR_W-1:0] X_CH_ADDR = 3'b101,
  parameter logic [TPS_ADDR_W-1:0] Y_CH_ADDR = 3'b001
) (
  input  phase_e     phase_q,
  input  frame_cfg_t cfg_q,
  output logic       x_en,
  output logic       y_en
);

  logic excite;

  assign excite = plate_wanted(phase_q, cfg_q.se);
  assign x_en   = excite && (cfg_q.chan == X_CH_ADDR);
  assign y_en   = excite && (cfg_q.chan == Y_CH_ADDR);

endmodule

// File: rtl/tps_switch_seq.sv
module tps_switch_seq
  import tps_pkg::*;
#(
  parameter logic [TPS_ADDR_W-1:0] X_CH_ADDR = 3'b101,
  parameter logic [TPS_ADDR_W-1:0] Y_CH_ADDR = 3'b001,
  parameter logic [TPS_PD_W-1:0]   PD_HOLD   = 2'b11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic [TPS_ADDR_W-1:0] chan_sel,
  input  logic                  single_ended,
  input  logic [TPS_PD_W-1:0]   pd_mode,
  input  logic                  acq_phase,
  input  logic                  conv_start,
  input  logic                  conv_end,
  output logic                  x_drv_en,
  output logic                  y_drv_en,
  output logic                  yneg_sw_en
);

  frame_cfg_t cfg_in;
  frame_cfg_t cfg_q;
  logic       cfg_diff;
  phase_e     phase_q;

  // Named internal events, in priority order.
  logic ev_deselect, ev_acq, ev_conv_start, ev_conv_end, ev_release;

  assign cfg_in = '{chan: chan_sel, se: single_ended, pd: pd_mode};

  assign ev_deselect   = cs_n;
  assign ev_acq        = !cs_n && acq_phase;
  assign ev_conv_start = !cs_n && !acq_phase && conv_start;
  assign ev_conv_end   = !cs_n && !acq_phase && !conv_start && conv_end
                         && (phase_q == PH_CONV);
  assign ev_release    = !cs_n && !acq_phase && !conv_start
                         && (phase_q == PH_HOLD) && cfg_diff;

  tps_cfg_latch u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (ev_acq || ev_conv_start),
    .cfg_in   (cfg_in),
    .cfg_q    (cfg_q),
    .cfg_diff (cfg_diff)
  );

  tps_phase_fsm #(.PD_HOLD(PD_HOLD)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_deselect   (ev_deselect),
    .ev_acq        (ev_acq),
    .ev_conv_start (ev_conv_start),
    .ev_conv_end   (ev_conv_end),
    .ev_release    (ev_release),
    .cfg_q         (cfg_q),
    .phase_q       (phase_q),
    .yneg_q        (yneg_sw_en)
  );

  tps_drive_map #(.X_CH_ADDR(X_CH_ADDR), .Y_CH_ADDR(Y_CH_ADDR)) u_map (
    .phase_q (phase_q),
    .cfg_q   (cfg_q),
    .x_en    (x_drv_en),
    .y_en    (y_drv_en)
  );

endmodule

// File: rtl/tps_switch_seq_chk.sv
module tps_switch_seq_chk
  import tps_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic [TPS_ADDR_W-1:0] chan_sel,
  input logic                  single_ended,
  input logic                  acq_phase,
  input logic                  conv_start,
  input logic                  ev_conv_end,
  input logic                  ev_release,
  input logic [TPS_PD_W-1:0]   pd_cap,
  input logic                  x_drv_en,
  input logic                  y_drv_en,
  input logic                  yneg_sw_en
);

  // R9
  xy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_drv_en && y_drv_en));

  // R9
  pull_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(yneg_sw_en && (x_drv_en || y_drv_en)));

  // R8
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!x_drv_en && !y_drv_en));

  // R8
  deselect_pull_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(yneg_sw_en));

  // R2
  acq_y_plate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && acq_phase && chan_sel == 3'b001) |=> y_drv_en);

  // R2
  acq_x_plate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && acq_phase && chan_sel == 3'b101) |=> x_drv_en);

  // R3
  se_conv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !acq_phase && conv_start && single_ended) |=> (!x_drv_en && !y_drv_en));

  // R5
  pull_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_conv_end && pd_cap != 2'b11) |=> (yneg_sw_en && !x_drv_en && !y_drv_en));

  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> (!x_drv_en && !y_drv_en));

endmodule

bind tps_switch_seq tps_switch_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .chan_sel     (chan_sel),
  .single_ended (single_ended),
  .acq_phase    (acq_phase),
  .conv_start   (conv_start),
  .ev_conv_end  (ev_conv_end),
  .ev_release   (ev_release),
  .pd_cap       (cfg_q.pd),
  .x_drv_en     (x_drv_en),
  .y_drv_en     (y_drv_en),
  .yneg_sw_en   (yneg_sw_en)
);

// File: tb/tb_tps_switch_seq.sv
module tb_tps_switch_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic [2:0] chan_sel = 3'd0;
  logic       single_ended = 1'b0;
  logic [1:0] pd_mode = 2'd0;
  logic       acq_phase = 1'b0;
  logic       conv_start = 1'b0;
  logic       conv_end = 1'b0;
  logic       x_drv_en, y_drv_en, yneg_sw_en;

  int    total = 0;
  int    bad = 0;
  string tag = "R1";
  bit    finished = 0;

  // Reference model state: 0 idle, 1 acquire, 2 convert, 3 hold.
  int m_ph = 0, m_ch = 0, m_se = 0, m_pd = 0, m_pull = 0;

  always #4 clk = ~clk;

  tps_switch_seq dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .chan_sel(chan_sel),
    .single_ended(single_ended), .pd_mode(pd_mode), .acq_phase(acq_phase),
    .conv_start(conv_start), .conv_end(conv_end),
    .x_drv_en(x_drv_en), .y_drv_en(y_drv_en), .yneg_sw_en(yneg_sw_en)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Model update on each edge, compare shortly after it.
  always @(posedge clk) begin
    int drive, ex, ey;
    if (!rst_n) begin
      m_ph = 0; m_ch = 0; m_se = 0; m_pd = 0; m_pull = 0;
    end else if (cs_n) begin
      m_ph = 0;
    end else if (acq_phase) begin
      m_ph = 1; m_pull = 0;
      m_ch = chan_sel; m_se = single_ended; m_pd = pd_mode;
    end else if (conv_start) begin
      m_ph = 2; m_pull = 0;
      m_ch = chan_sel; m_se = single_ended; m_pd = pd_mode;
    end else if (conv_end && m_ph == 2) begin
      if (m_pd == 3) begin
        m_ph = (m_se == 0) ? 3 : 0;
        m_pull = 0;
      end else begin
        m_ph = 0;
        m_pull = 1;
      end
    end else if (m_ph == 3 && (chan_sel != m_ch || single_ended != m_se || pd_mode != m_pd)) begin
      m_ph = 0;
    end
    #2;
    if (rst_n) begin
      drive = (m_ph == 1) || (m_ph == 3) || (m_ph == 2 && m_se == 0);
      ex = drive && (m_ch == 5);
      ey = drive && (m_ch == 1);
      check(tag, x_drv_en, ex, "x_drv_en");
      check(tag, y_drv_en, ey, "y_drv_en");
      check(tag, yneg_sw_en, m_pull, "yneg_sw_en");
      check("R9", (x_drv_en && y_drv_en) || (yneg_sw_en && (x_drv_en || y_drv_en)), 0, "overlap");
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic frame(input int ch, input int se, input int pd,
                       input int acq_n, input int conv_n, input string t);
    tag = t;
    tick();
    cs_n = 1'b0; chan_sel = 3'(ch); single_ended = 1'(se); pd_mode = 2'(pd);
    acq_phase = 1'b1;
    repeat (acq_n) tick();
    acq_phase = 1'b0; conv_start = 1'b1;
    tick();
    conv_start = 1'b0;
    repeat (conv_n) tick();
    conv_end = 1'b1;
    tick();
    conv_end = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", x_drv_en, 0, "x in reset");
    check("R1", y_drv_en, 0, "y in reset");
    check("R1", yneg_sw_en, 0, "pull in reset");
    rst_n = 1'b1;
    tick();
    check("R1", {x_drv_en, y_drv_en, yneg_sw_en}, 0, "after reset");

    // R2: plate selection per channel
    frame(1, 0, 0, 3, 4, "R2");
    frame(5, 0, 1, 3, 4, "R2");
    frame(2, 0, 0, 2, 3, "R2");
    frame(0, 1, 2, 2, 3, "R2");
    frame(6, 0, 3, 2, 3, "R2");
    frame(7, 1, 1, 2, 3, "R2");
    // direct: acquisition on Y+ channel enables X plate
    tag = "R2"; tick();
    chan_sel = 3'd5; acq_phase = 1'b1; tick();
    check("R2", x_drv_en, 1, "x during Y+ acquire");
    check("R2", y_drv_en, 0, "y during Y+ acquire");
    chan_sel = 3'd1; tick();
    check("R2", y_drv_en, 1, "y after mid-acquire switch");
    acq_phase = 1'b0;

    // R3: single-ended releases at conversion start
    frame(5, 1, 2, 3, 5, "R3");
    frame(1, 1, 0, 1, 2, "R3");
    // R4: ratiometric holds through long conversion
    frame(1, 0, 2, 2, 12, "R4");
    frame(5, 0, 0, 4, 8, "R4");

    // R5: pull stays until next acquisition
    tag = "R5"; repeat (6) tick();
    check("R5", yneg_sw_en, 1, "pull persists while idle");
    acq_phase = 1'b1; chan_sel = 3'd1; tick();
    check("R5", yneg_sw_en, 0, "pull cleared by acquire");
    acq_phase = 1'b0;

    // R6: hold code, ratiometric and single-ended
    frame(1, 0, 3, 2, 4, "R6");
    repeat (5) tick();
    check("R6", y_drv_en, 1, "held after conversion");
    check("R6", yneg_sw_en, 0, "no pull on hold");
    // R7: release by channel change
    tag = "R7"; chan_sel = 3'd2; tick(); tick();
    check("R7", y_drv_en, 0, "released on channel change");
    frame(5, 0, 3, 2, 3, "R7");
    single_ended = 1'b1; tick(); tick();
    check("R7", x_drv_en, 0, "released on mode change");
    frame(5, 0, 3, 2, 3, "R7");
    pd_mode = 2'd1; tick(); tick();
    check("R7", x_drv_en, 0, "released on pd change");
    frame(1, 1, 3, 2, 3, "R6");
    tick();
    check("R6", {y_drv_en, yneg_sw_en}, 0, "single-ended hold code");

    // R8: deselect during hold and with pull on
    frame(1, 0, 3, 2, 3, "R8");
    cs_n = 1'b1; tick(); tick();
    check("R8", y_drv_en, 0, "deselect drops held plate");
    frame(5, 0, 1, 2, 3, "R8");
    cs_n = 1'b1; repeat (3) tick();
    check("R8", yneg_sw_en, 1, "pull survives deselect");
    frame(1, 0, 0, 3, 0, "R8");
    cs_n = 1'b0; acq_phase = 1'b1; tick();
    cs_n = 1'b1; tick();
    check("R8", y_drv_en, 0, "deselect mid-acquire");
    acq_phase = 1'b0;

    // R10: strobe priority
    tag = "R10"; cs_n = 1'b0; chan_sel = 3'd1; single_ended = 1'b0; pd_mode = 2'd0;
    acq_phase = 1'b1; conv_start = 1'b1; tick(); tick();
    conv_start = 1'b0; tick();
    check("R10", y_drv_en, 1, "acquire wins over conv_start");
    acq_phase = 1'b0; conv_end = 1'b1; tick(); tick();
    check("R10", yneg_sw_en, 0, "conv_end ignored outside conversion");
    conv_end = 1'b0;

    // R9: random stimulus
    tag = "R9";
    for (int i = 0; i < 600; i++) begin
      cs_n = ($urandom_range(0, 15) == 0);
      chan_sel = ($urandom_range(0, 1) != 0) ? 3'd1 : (($urandom_range(0, 1) != 0) ? 3'd5 : 3'($urandom));
      single_ended = 1'($urandom);
      pd_mode = ($urandom_range(0, 1) != 0) ? 2'd3 : 2'($urandom);
      acq_phase = ($urandom_range(0, 3) == 0);
      conv_start = ($urandom_range(0, 4) == 0);
      conv_end = ($urandom_range(0, 3) == 0);
      tick();
    end
    cs_n = 1'b1; acq_phase = 1'b0; conv_start = 1'b0; conv_end = 1'b0;
    repeat (3) tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule